// File: doc/BRIEF.md
# PRBS7 Lane Checker with Lock Training

This block checks a single serial lane that carries a PRBS7 pattern (x^7 + x^6 + 1), one bit per clock when the valid flag is high. While training, it loads every received bit into its own shift register, so the register aligns itself to the incoming stream. From the eighth accepted bit on, it compares each bit against the value it predicts. It declares lock once a programmable number of predictions in a row have matched.

Once locked, the shift register runs on its own predictions. Every received bit that differs from the prediction adds one to a 17-bit error counter. A 2-bit select picks a ceiling for that counter. When the count reaches the ceiling, the checker stops by itself and holds the count. Dropping the enable returns the checker to idle and clears everything.

Top module: `prbs_lock_checker`

## Requirements
- R1: With `train_len` = N (9 is the usual setting, 0 behaves as 1), the first 7 accepted bits after training starts only fill the shift register. `train_done` rises on the clock edge that accepts the N-th matching prediction in a row, which is the (7+N)-th accepted bit of a clean stream.
- R2: `train_active` is 1 exactly while the checker is enabled and training. It is 0 in idle, after lock and after a stop.
- R3: `train_done` stays 1 from lock until the enable drops, including after a stop. `train_active` and `train_done` are never both 1.
- R4: During training, a bit that differs from the prediction sets the match run back to zero and training goes on. Lock then needs N fresh matches in a row.
- R5: Each received bit should equal the bit 7 places back XOR the bit 6 places back. After lock, a bit that breaks this rule with respect to the free-running local sequence adds exactly one to `err_count`. Matching bits add nothing.
- R6: Mismatches seen before lock never change `err_count`, which reads 0 while training.
- R7: `ceil_sel` encodes the ceiling as 00 = 65536, 01 = 1024, 10 = 256, 11 = 16. The clock edge that takes `err_count` to the ceiling also sets `stopped`. After that the count does not change.
- R8: While `enable` is 0, all outputs read 0 one edge later. The edge that first samples `enable` = 1 moves the checker into training, and a bit presented on that edge is not used.
- R9: A cycle with `bit_valid` = 0 has no effect, in training or after lock, whatever `bit_in` holds.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the checker; 0 clears it |
| bit_in | input | 1 | Received serial bit |
| bit_valid | input | 1 | `bit_in` is used in this cycle |
| train_len | input | 4 | Consecutive matches needed for lock |
| ceil_sel | input | 2 | Error-count ceiling code |
| train_active | output | 1 | Training in progress |
| train_done | output | 1 | Checker locked to the stream |
| err_count | output | 17 | Errors counted since lock |
| stopped | output | 1 | Ceiling reached, comparing halted |

## Verification
The assertions check, on every cycle, the properties that do not depend on the data:
- training and lock are never both reported;
- a stop implies lock;
- the count stays zero while training;
- the count moves by at most one per edge, and only on a valid bit;
- the count is frozen after a stop;
- disabling the checker clears it.

Only the bench's scenarios can show the values that follow from the pattern itself:
- the exact bit on which lock arrives for each training length;
- the restart after a mid-training mismatch;
- the exact count at which each of the four ceilings stops the checker.

// File: rtl/prbs_chk_pkg.sv
// Package: shared phase encoding and error-ceiling decode for the PRBS lane checker.
// Assumes: the error counter is ERR_W bits wide, enough to hold the largest ceiling.
package prbs_chk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRAIN = 2'd1,
        PH_LOCK  = 2'd2,
        PH_HALT  = 2'd3
    } phase_t;

    localparam int ERR_W      = 17;
    localparam int CEIL_EXP_0 = 16;
    localparam int CEIL_EXP_1 = 10;
    localparam int CEIL_EXP_2 = 8;
    localparam int CEIL_EXP_3 = 4;

    // Maps the 2-bit ceiling code to the error count that stops the checker.
    function automatic logic [ERR_W-1:0] ceiling_of(input logic [1:0] sel);
        logic [ERR_W-1:0] one;
        one = ERR_W'(1);
        case (sel)
            2'b00:   return one << CEIL_EXP_0;
            2'b01:   return one << CEIL_EXP_1;
            2'b10:   return one << CEIL_EXP_2;
            default: return one << CEIL_EXP_3;
        endcase
    endfunction

endpackage

// File: rtl/prbs_track.sv
// Module: local PRBS shift register.
// In seed mode each accepted bit is shifted in, so the register aligns itself to the stream.
// Otherwise it shifts in its own prediction and runs free.
// The prediction is the XOR of two taps; 'filled' says LEN bits have been loaded since clear.
// Assumes: TAP_HI and TAP_LO index into the LEN-bit register, with bit 0 the newest bit.
module prbs_track #(
    parameter int LEN    = 7,
    parameter int TAP_HI = 6,
    parameter int TAP_LO = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic seed_mode,
    input  logic bit_in,
    output logic predict,
    output logic filled
);
    localparam int FILL_W = $clog2(LEN + 1);

    logic [LEN-1:0]    shreg;
    logic [FILL_W-1:0] fill;

    assign predict = shreg[TAP_HI] ^ shreg[TAP_LO];
    assign filled  = (fill == FILL_W'(LEN));

    // Shift register: loads received bits while seeding, runs on predictions after lock.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
        end else if (step) begin
            shreg <= {shreg[LEN-2:0], (seed_mode ? bit_in : predict)};
        end
    end

    // Fill counter: counts seeded bits up to LEN.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fill <= '0;
        end else if (step && seed_mode && !filled) begin
            fill <= fill + FILL_W'(1);
        end
    end
endmodule

// File: rtl/lock_trainer.sv
// Module: counts matching predictions in a row during training.
// It raises lock_now on the step that completes the required run.
// A mismatch, or a step taken before the register is filled, sets the run back to zero.
// Assumes: a required length of 0 acts as 1.
module lock_trainer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             filled,
    input  logic             match,
    input  logic [CNT_W-1:0] train_len,
    output logic             lock_now
);
    localparam int RUN_W = CNT_W + 1;

    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] run_inc;
    logic [RUN_W-1:0] need;

    // Required run length, with 0 promoted to 1.
    always_comb begin
        need    = (train_len == '0) ? RUN_W'(1) : {1'b0, train_len};
        run_inc = run + RUN_W'(1);
    end

    assign lock_now = step && filled && match && (run_inc >= need);

    // Match run counter: counts up on a match, saturates, clears on a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run <= '0;
        end else if (step) begin
            if (filled && match) begin
                run <= (run == '1) ? run : run_inc;
            end else begin
                run <= '0;
            end
        end
    end
endmodule

// File: rtl/err_tally.sv
// Module: error counter that saturates at a ceiling.
// It adds one for each stepped mismatch while below the ceiling.
// reach_next says the value about to be registered is at or above the ceiling.
// Assumes: the ceiling fits in ERR_W bits.
module err_tally #(
    parameter int ERR_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             miss,
    input  logic [ERR_W-1:0] ceiling,
    output logic [ERR_W-1:0] count,
    output logic             reach_next
);
    logic [ERR_W-1:0] count_next;

    // Next count: add one for a mismatch, never past the ceiling.
    always_comb begin
        count_next = count;
        if (step && miss && (count < ceiling)) begin
            count_next = count + ERR_W'(1);
        end
        reach_next = (count_next >= ceiling);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else begin
            count <= count_next;
        end
    end
endmodule

// File: rtl/prbs_lock_checker.sv
// Module: top of the PRBS7 lane checker.
// Phases: idle -> training (self-seeding) -> locked (counting errors) -> stopped (ceiling reached).
// Dropping enable returns the checker to idle and clears all state.
// Assumes: one serial bit per cycle, qualified by bit_valid.
module prbs_lock_checker
    import prbs_chk_pkg::*;
#(
    parameter int PRBS_LEN = 7,
    parameter int TAP_HI   = 6,
    parameter int TAP_LO   = 5,
    parameter int CNT_W    = 4,
    parameter int CNT_BITS = ERR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                bit_in,
    input  logic                bit_valid,
    input  logic [CNT_W-1:0]    train_len,
    input  logic [1:0]          ceil_sel,
    output logic                train_active,
    output logic                train_done,
    output logic [CNT_BITS-1:0] err_count,
    output logic                stopped
);
    phase_t              phase;
    logic                clear;
    logic                step_train;
    logic                step_lock;
    logic                predict;
    logic                filled;
    logic                lock_now;
    logic                reach_next;
    logic [CNT_BITS-1:0] ceiling;

    assign clear      = !enable;
    assign step_train = enable && bit_valid && (phase == PH_TRAIN);
    assign step_lock  = enable && bit_valid && (phase == PH_LOCK);
    assign ceiling    = CNT_BITS'(ceiling_of(ceil_sel));

    prbs_track #(
        .LEN    (PRBS_LEN),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .step      (step_train || step_lock),
        .seed_mode (phase == PH_TRAIN),
        .bit_in    (bit_in),
        .predict   (predict),
        .filled    (filled)
    );

    lock_trainer #(
        .CNT_W (CNT_W)
    ) u_trainer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .step      (step_train),
        .filled    (filled),
        .match     (bit_in == predict),
        .train_len (train_len),
        .lock_now  (lock_now)
    );

    err_tally #(
        .ERR_W (CNT_BITS)
    ) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .step       (step_lock),
        .miss       (bit_in != predict),
        .ceiling    (ceiling),
        .count      (err_count),
        .reach_next (reach_next)
    );

    // Phase sequencer: enable low forces idle; lock and ceiling events advance the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:  phase <= PH_TRAIN;
                PH_TRAIN: if (lock_now)   phase <= PH_LOCK;
                PH_LOCK:  if (reach_next) phase <= PH_HALT;
                default:  phase <= PH_HALT;
            endcase
        end
    end

    assign train_active = (phase == PH_TRAIN);
    assign train_done   = (phase == PH_LOCK) || (phase == PH_HALT);
    assign stopped      = (phase == PH_HALT);
endmodule

// File: rtl/prbs_lock_checker_chk.sv
// Module: assertion checker for prbs_lock_checker, attached by bind.
// It watches the top-level ports only.
module prbs_lock_checker_chk #(
    parameter int CNT_BITS = 17
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                bit_valid,
    input logic                train_active,
    input logic                train_done,
    input logic [CNT_BITS-1:0] err_count,
    input logic                stopped
);
    // R3
    excl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(train_active && train_done));

    // R7
    stop_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> train_done);

    // R6
    train_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_active |-> (err_count == '0));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stopped) |=> $stable(err_count));

    // R9
    novalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_valid) |=> $stable(err_count));

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ((err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1)));

    // R8
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!train_active && !train_done && !stopped && err_count == '0));

    // R1
    done_from_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_done) |-> $past(train_active));
endmodule

bind prbs_lock_checker prbs_lock_checker_chk #(.CNT_BITS(CNT_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .bit_valid    (bit_valid),
    .train_active (train_active),
    .train_done   (train_done),
    .err_count    (err_count),
    .stopped      (stopped)
);

// File: tb/prbs_lock_checker_bench.sv
`timescale 1ns/1ps
// Bench: a table of training lengths and expected lock points, walked in one loop.
// Directed tests follow for reset, mismatch restart, valid gaps, ceilings and disable.
module prbs_lock_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        bit_in;
    logic        bit_valid;
    logic [3:0]  train_len;
    logic [1:0]  ceil_sel;
    logic        train_active;
    logic        train_done;
    logic [16:0] err_count;
    logic        stopped;

    int checks = 0;
    int errors = 0;
    logic [6:0] hist;

    localparam int NROW = 5;
    localparam logic [3:0] TL_TAB  [NROW] = '{4'd9, 4'd1, 4'd0, 4'd15, 4'd3};
    localparam int         LOCK_AT [NROW] = '{16, 8, 8, 22, 10};

    always #2.5 clk = ~clk;

    prbs_lock_checker u_prbs_lock_checker (
        .clk (clk), .rst_n (rst_n), .enable (enable), .bit_in (bit_in),
        .bit_valid (bit_valid), .train_len (train_len), .ceil_sel (ceil_sel),
        .train_active (train_active), .train_done (train_done),
        .err_count (err_count), .stopped (stopped)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sends one valid bit. flip inverts it; keep decides whether the inverted bit joins the true stream.
    task automatic send(input logic flip, input logic keep);
        logic p;
        p = hist[6] ^ hist[5];
        bit_in    = p ^ flip;
        bit_valid = 1'b1;
        hist      = {hist[5:0], (keep ? (p ^ flip) : p)};
        @(negedge clk);
    endtask

    task automatic gap(input logic junk);
        bit_valid = 1'b0;
        bit_in    = junk;
        @(negedge clk);
    endtask

    task automatic start(input logic [3:0] tl, input logic [1:0] cs, input logic [6:0] seed);
        enable    = 1'b0;
        bit_valid = 1'b0;
        @(negedge clk);
        train_len = tl;
        ceil_sel  = cs;
        hist      = seed;
        enable    = 1'b1;
        @(negedge clk);
    endtask

    task automatic lock_fast(input logic [1:0] cs);
        start(4'd1, cs, 7'h2B);
        for (int n = 0; n < 8; n++) send(1'b0, 1'b0);
    endtask

    initial begin
        #999_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        train_len = 4'd9; ceil_sel = 2'b00; hist = 7'h55;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 outputs after reset", {train_active, train_done, stopped, err_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle while disabled", {train_active, train_done, stopped}, 0);

        // R1 / R2 table of training lengths
        for (int i = 0; i < NROW; i++) begin
            start(TL_TAB[i], 2'b00, 7'h13 + 7'(i * 11));
            chk("R8 training after enable", train_active, 1);
            for (int n = 1; n <= LOCK_AT[i]; n++) begin
                send(1'b0, 1'b0);
                if (n == LOCK_AT[i] - 1) begin
                    chk("R1 not locked one bit early", train_done, 0);
                    chk("R2 active before lock", train_active, 1);
                end
                if (n == LOCK_AT[i]) begin
                    chk("R1 locked at expected bit", train_done, 1);
                    chk("R2 inactive after lock", train_active, 0);
                end
            end
        end

        // R4 / R6 mismatch in training restarts the run (train_len 4, ceiling 16)
        start(4'd4, 2'b11, 7'h6D);
        for (int n = 0; n < 10; n++) send(1'b0, 1'b0);
        send(1'b1, 1'b1);
        chk("R6 no count while training", err_count, 0);
        for (int n = 0; n < 3; n++) send(1'b0, 1'b0);
        chk("R4 run restarted, not yet locked", train_done, 0);
        send(1'b0, 1'b0);
        chk("R4 locked after fresh run", train_done, 1);

        // R5 clean bits after lock count nothing, flipped bits count once each
        for (int n = 0; n < 5; n++) send(1'b0, 1'b0);
        chk("R5 clean locked stream", err_count, 0);
        for (int n = 0; n < 10; n++) send(1'b1, 1'b0);
        chk("R5 ten errors counted", err_count, 10);
        // R9 valid low with junk has no effect after lock
        for (int n = 0; n < 5; n++) gap(n[0]);
        chk("R9 gaps ignored after lock", err_count, 10);
        for (int n = 0; n < 5; n++) send(1'b1, 1'b0);
        chk("R7 not stopped below 16", {stopped, err_count}, 15);
        send(1'b1, 1'b0);
        chk("R7 ceiling 16 count", err_count, 16);
        chk("R7 ceiling 16 stopped", stopped, 1);
        for (int n = 0; n < 3; n++) send(1'b1, 1'b0);
        chk("R7 count held after stop", err_count, 16);
        chk("R3 done held after stop", train_done, 1);

        // R8 disable clears everything
        enable = 1'b0;
        @(negedge clk);
        chk("R8 cleared on disable", {train_active, train_done, stopped, err_count}, 0);

        // R9 gaps during training do not break the run
        start(4'd3, 2'b00, 7'h41);
        for (int n = 0; n < 7; n++) send(1'b0, 1'b0);
        for (int n = 0; n < 4; n++) gap(n[1]);
        for (int n = 0; n < 2; n++) send(1'b0, 1'b0);
        chk("R9 gaps ignored in training", train_done, 0);
        send(1'b0, 1'b0);
        chk("R9 lock after gapped run", train_done, 1);

        // R7 ceiling 256
        lock_fast(2'b10);
        for (int n = 0; n < 255; n++) send(1'b1, 1'b0);
        chk("R7 below 256", {stopped, err_count}, 255);
        send(1'b1, 1'b0);
        chk("R7 ceiling 256", {stopped, err_count}, (1 << 17) + 256);

        // R7 ceiling 1024
        lock_fast(2'b01);
        for (int n = 0; n < 1023; n++) send(1'b1, 1'b0);
        chk("R7 below 1024", {stopped, err_count}, 1023);
        send(1'b1, 1'b0);
        chk("R7 ceiling 1024", {stopped, err_count}, (1 << 17) + 1024);

        // R7 ceiling 65536
        lock_fast(2'b00);
        for (int n = 0; n < 65535; n++) send(1'b1, 1'b0);
        chk("R7 below 65536", {stopped, err_count}, 65535);
        send(1'b1, 1'b0);
        chk("R7 ceiling 65536", {stopped, err_count}, (1 << 17) + 65536);
        for (int n = 0; n < 4; n++) send(1'b1, 1'b0);
        chk("R7 65536 held", err_count, 65536);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule